// File: doc/BRIEF.md
# Indirect Interrupt Redirection Table Unit

This unit routes up to 24 external interrupt pins to processor-bound delivery messages. Every pin has its own 64-bit redirection entry. The entry selects the vector, the delivery mode, physical or logical destination addressing, the pin polarity, edge or level triggering, a mask bit and a 4-bit destination. Software never addresses an entry directly. It writes a register index into a select register, then reads or writes the chosen 32-bit register through a data window. Each entry therefore takes two consecutive indices, the low half first.

The unit samples its pins every clock. An unmasked pin that becomes asserted is queued. The lowest queued pin index is loaded into an output slot and offered on a valid/ready message port. Level-triggered pins also set a remote-IRR flag when their message is accepted, and they stay quiet until an end-of-interrupt carrying their vector clears that flag.

Top module: `irq_route_unit`

## Requirements
- R1: A bus write at address 0x00 loads the 8-bit select index, and a read there returns it in bits 7:0. Bus address 0x10 is the window: reads and writes there reach the register named by the select index.
- R2: Index 0x01 reads the version in bits 7:0 and the highest entry number (NUM_PINS-1, 23 by default) in bits 23:16; it cannot be written. Index 0x00 holds a writable 4-bit unit identifier in bits 27:24. Index 0x02 reads the same identifier and ignores writes.
- R3: Entry n sits at index 0x10+2n (low word) and 0x11+2n (high word). Low-word bits: 7:0 vector, 10:8 delivery mode (0 fixed, 1 lowest priority, 2 system management, 4 non-maskable, 5 init, 7 external), 11 logical destination, 12 delivery status, 13 active low, 14 remote IRR, 15 level trigger, 16 mask. High-word bits 27:24 hold the destination.
- R4: After reset every entry reads low word 0x00010000 (masked, all else zero) and high word 0, and no message is offered.
- R5: Indices with no register behind them read zero. Writes to bits 12 and 14 of a low word, and to any unimplemented bit, have no effect.
- R6: A pin counts as asserted when its raw level XOR its active-low bit is 1.
- R7: An unmasked edge-triggered pin queues one message per not-asserted to asserted transition. Holding it asserted queues nothing more.
- R8: An unmasked level-triggered pin queues a message while asserted with remote IRR clear. Acceptance of that message sets remote IRR, which blocks further messages until an end-of-interrupt with a matching vector clears it. An end-of-interrupt with another vector has no effect.
- R9: Delivery status reads 1 from the cycle a message is queued until the cycle its message is accepted.
- R10: The message port carries vector, destination, delivery mode and destination mode. The fields hold steady while msg_valid is high and msg_ready low. Among queued pins the lowest index is offered first.
- R11: A masked pin queues nothing. An edge that occurs while the pin is masked is dropped, so unmasking a pin that is held asserted queues nothing.
- R12: When a level message is accepted in the same cycle as an end-of-interrupt for its vector, remote IRR ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address: 0x00 select, 0x10 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NUM_PINS | Raw interrupt pin levels |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | Delivery message offered |
| msg_ready | input | 1 | Consumer accepts the message |
| msg_vector | output | 8 | Message vector |
| msg_dest | output | 4 | Message destination |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | Destination mode, 1 = logical |

## Verification
Two events can land on one level pin in the same clock: the consumer accepts its message, which sets remote IRR, and an end-of-interrupt with its vector arrives, which clears remote IRR. The bench waits for a level message to be offered. At one falling edge it then raises msg_ready and drives a matching end-of-interrupt. The result is judged by reading the entry back through the window, which must show remote IRR set, and by confirming that no further message appears while the pin stays asserted.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

    localparam int          REG_W    = 32;
    localparam int          SEL_W    = 8;
    localparam int          DEST_W   = 4;
    localparam int          TBL_BASE = 16;
    localparam logic [7:0]  ADDR_SEL = 8'h00;
    localparam logic [7:0]  ADDR_WIN = 8'h10;
    localparam logic [7:0]  IDX_ID   = 8'h00;
    localparam logic [7:0]  IDX_VER  = 8'h01;
    localparam logic [7:0]  IDX_ARB  = 8'h02;

    // Per-pin configuration held in the redirection entry
    typedef struct packed {
        logic [DEST_W-1:0] dest;
        logic              masked;
        logic              level;
        logic              act_low;
        logic              logical;
        logic [2:0]        mode;
        logic [7:0]        vector;
    } rte_cfg_t;

    localparam rte_cfg_t CFG_RESET = '{dest: '0, masked: 1'b1, level: 1'b0,
                                       act_low: 1'b0, logical: 1'b0,
                                       mode: 3'd0, vector: 8'd0};

    typedef struct packed {
        logic [7:0]        vector;
        logic [DEST_W-1:0] dest;
        logic [2:0]        mode;
        logic              logical;
    } route_msg_t;

    function automatic rte_cfg_t cfg_load_lo(rte_cfg_t old, logic [REG_W-1:0] w);
        rte_cfg_t c;
        c         = old;
        c.vector  = w[7:0];
        c.mode    = w[10:8];
        c.logical = w[11];
        c.act_low = w[13];
        c.level   = w[15];
        c.masked  = w[16];
        return c;
    endfunction

    function automatic rte_cfg_t cfg_load_hi(rte_cfg_t old, logic [REG_W-1:0] w);
        rte_cfg_t c;
        c      = old;
        c.dest = w[27:24];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] lo_image(rte_cfg_t c, logic pend, logic rirr);
        return {15'd0, c.masked, c.level, rirr, c.act_low, pend,
                c.logical, c.mode, c.vector};
    endfunction

    function automatic logic [REG_W-1:0] hi_image(rte_cfg_t c);
        return {4'd0, c.dest, 24'd0};
    endfunction

endpackage

// File: rtl/rte_pin_slot.sv
module rte_pin_slot
    import irq_route_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic [REG_W-1:0] wdata,
    input  logic             pin_raw,
    input  logic             eoi_valid,
    input  logic [7:0]       eoi_vector,
    input  logic             accept,
    output rte_cfg_t         cfg,
    output logic             pend,
    output logic             rirr
);

    logic act;
    logic act_prev;
    logic raise;

    assign act = pin_raw ^ cfg.act_low;

    always_comb begin
        if (cfg.masked)
            raise = 1'b0;
        else if (cfg.level)
            raise = act & ~rirr & ~pend;
        else
            raise = act & ~act_prev;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_RESET;
            pend     <= 1'b0;
            rirr     <= 1'b0;
            act_prev <= 1'b0;
        end else begin
            if (wr_lo)
                cfg <= cfg_load_lo(cfg, wdata);
            else if (wr_hi)
                cfg <= cfg_load_hi(cfg, wdata);
            act_prev <= act;
            pend     <= (pend & ~accept) | raise;
            if (accept && cfg.level)
                rirr <= 1'b1;
            else if (eoi_valid && cfg.level && eoi_vector == cfg.vector)
                rirr <= 1'b0;
        end
    end

endmodule

// File: rtl/rte_window.sv
module rte_window
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           bus_wr,
    input  logic [7:0]                     bus_addr,
    input  logic [REG_W-1:0]               bus_wdata,
    input  logic [NUM_PINS-1:0][REG_W-1:0] lo_words,
    input  logic [NUM_PINS-1:0][REG_W-1:0] hi_words,
    output logic [REG_W-1:0]               bus_rdata,
    output logic [NUM_PINS-1:0]            wr_lo,
    output logic [NUM_PINS-1:0]            wr_hi
);

    localparam logic [7:0] MAX_ENTRY = 8'(NUM_PINS - 1);

    logic [SEL_W-1:0]  sel_q;
    logic [3:0]        unit_id_q;
    logic              win_wr;
    logic [REG_W-1:0]  win_rd;
    logic [REG_W-1:0]  id_word;

    assign win_wr  = bus_wr && (bus_addr == ADDR_WIN);
    assign id_word = {4'd0, unit_id_q, 24'd0};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= '0;
            unit_id_q <= '0;
        end else begin
            if (bus_wr && bus_addr == ADDR_SEL)
                sel_q <= bus_wdata[SEL_W-1:0];
            if (win_wr && sel_q == IDX_ID)
                unit_id_q <= bus_wdata[27:24];
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_dec
        localparam logic [7:0] LO_IDX = 8'(TBL_BASE + 2 * i);
        localparam logic [7:0] HI_IDX = 8'(TBL_BASE + 2 * i + 1);
        assign wr_lo[i] = win_wr && (sel_q == LO_IDX);
        assign wr_hi[i] = win_wr && (sel_q == HI_IDX);
    end

    always_comb begin
        win_rd = '0;
        case (sel_q)
            IDX_ID:  win_rd = id_word;
            IDX_VER: win_rd = {8'd0, MAX_ENTRY, 8'd0, VERSION};
            IDX_ARB: win_rd = id_word;
            default: begin
                for (int i = 0; i < NUM_PINS; i++) begin
                    if (sel_q == 8'(TBL_BASE + 2 * i))
                        win_rd = lo_words[i];
                    if (sel_q == 8'(TBL_BASE + 2 * i + 1))
                        win_rd = hi_words[i];
                end
            end
        endcase
    end

    always_comb begin
        case (bus_addr)
            ADDR_SEL: bus_rdata = {{(REG_W-SEL_W){1'b0}}, sel_q};
            ADDR_WIN: bus_rdata = win_rd;
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/rte_dispatch.sv
module rte_dispatch
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_PINS-1:0]      pend,
    input  rte_cfg_t [NUM_PINS-1:0]  cfg,
    input  logic                     msg_ready,
    output logic                     msg_valid,
    output route_msg_t               msg,
    output logic [NUM_PINS-1:0]      acc_oh
);

    localparam int IDX_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic             found;
    logic [IDX_W-1:0] pick;
    logic [IDX_W-1:0] slot_idx;

    // Lowest queued index wins
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int i = NUM_PINS - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                pick  = IDX_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid <= 1'b0;
            slot_idx  <= '0;
            msg       <= '0;
        end else if (msg_valid) begin
            if (msg_ready)
                msg_valid <= 1'b0;
        end else if (found) begin
            msg_valid   <= 1'b1;
            slot_idx    <= pick;
            msg.vector  <= cfg[pick].vector;
            msg.dest    <= cfg[pick].dest;
            msg.mode    <= cfg[pick].mode;
            msg.logical <= cfg[pick].logical;
        end
    end

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_acc
        assign acc_oh[i] = msg_valid && msg_ready && (slot_idx == IDX_W'(i));
    end

endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
    import irq_route_pkg::*;
#(
    parameter int         NUM_PINS = 24,
    parameter logic [7:0] VERSION  = 8'h11
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic                eoi_valid,
    input  logic [7:0]          eoi_vector,
    output logic                msg_valid,
    input  logic                msg_ready,
    output logic [7:0]          msg_vector,
    output logic [3:0]          msg_dest,
    output logic [2:0]          msg_mode,
    output logic                msg_logical
);

    rte_cfg_t [NUM_PINS-1:0]        cfg_q;
    logic [NUM_PINS-1:0]            pend_q;
    logic [NUM_PINS-1:0]            rirr_q;
    logic [NUM_PINS-1:0]            acc_oh;
    logic [NUM_PINS-1:0]            wr_lo;
    logic [NUM_PINS-1:0]            wr_hi;
    logic [NUM_PINS-1:0][REG_W-1:0] lo_words;
    logic [NUM_PINS-1:0][REG_W-1:0] hi_words;
    route_msg_t                     msg;

    rte_window #(.NUM_PINS(NUM_PINS), .VERSION(VERSION)) u_window (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .lo_words  (lo_words),
        .hi_words  (hi_words),
        .bus_rdata (bus_rdata),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        rte_pin_slot u_slot (
            .clk        (clk),
            .rst        (rst),
            .wr_lo      (wr_lo[i]),
            .wr_hi      (wr_hi[i]),
            .wdata      (bus_wdata),
            .pin_raw    (pin_in[i]),
            .eoi_valid  (eoi_valid),
            .eoi_vector (eoi_vector),
            .accept     (acc_oh[i]),
            .cfg        (cfg_q[i]),
            .pend       (pend_q[i]),
            .rirr       (rirr_q[i])
        );
        assign lo_words[i] = lo_image(cfg_q[i], pend_q[i], rirr_q[i]);
        assign hi_words[i] = hi_image(cfg_q[i]);
    end

    rte_dispatch #(.NUM_PINS(NUM_PINS)) u_dispatch (
        .clk       (clk),
        .rst       (rst),
        .pend      (pend_q),
        .cfg       (cfg_q),
        .msg_ready (msg_ready),
        .msg_valid (msg_valid),
        .msg       (msg),
        .acc_oh    (acc_oh)
    );

    assign msg_vector  = msg.vector;
    assign msg_dest    = msg.dest;
    assign msg_mode    = msg.mode;
    assign msg_logical = msg.logical;

endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
    import irq_route_pkg::*;
#(
    parameter int NUM_PINS = 24
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    msg_valid,
    input logic                    msg_ready,
    input logic [7:0]              msg_vector,
    input logic [3:0]              msg_dest,
    input logic [2:0]              msg_mode,
    input logic [NUM_PINS-1:0]     pend,
    input logic [NUM_PINS-1:0]     rirr,
    input logic [NUM_PINS-1:0]     acc_oh,
    input rte_cfg_t [NUM_PINS-1:0] cfg
);

    logic [NUM_PINS-1:0] mask_v;
    logic [NUM_PINS-1:0] lvl_v;
    logic [NUM_PINS-1:0] acc_lvl;

    always_comb begin
        for (int i = 0; i < NUM_PINS; i++) begin
            mask_v[i] = cfg[i].masked;
            lvl_v[i]  = cfg[i].level;
        end
    end
    assign acc_lvl = acc_oh & lvl_v;

    AST_MSG_HOLD: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_vector)
                                    && $stable(msg_dest) && $stable(msg_mode)); // R10

    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(acc_oh)); // R10

    AST_VALID_HAS_STATUS: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (pend != '0)); // R9

    AST_LEVEL_ACCEPT_SETS_RIRR: assert property (@(posedge clk) disable iff (rst)
        (acc_lvl != '0) |=> ((rirr & $past(acc_lvl)) == $past(acc_lvl))); // R12

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&mask_v) && !msg_valid); // R4

endmodule

bind irq_route_unit irq_route_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .msg_valid  (msg_valid),
    .msg_ready  (msg_ready),
    .msg_vector (msg_vector),
    .msg_dest   (msg_dest),
    .msg_mode   (msg_mode),
    .pend       (pend_q),
    .rirr       (rirr_q),
    .acc_oh     (acc_oh),
    .cfg        (cfg_q)
);

// File: tb/test_irq_route_unit.sv
module test_irq_route_unit;

    localparam int NP = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic          eoi_valid = 1'b0;
    logic [7:0]    eoi_vector = '0;
    logic          msg_valid;
    logic          msg_ready = 1'b0;
    logic [7:0]    msg_vector;
    logic [3:0]    msg_dest;
    logic [2:0]    msg_mode;
    logic          msg_logical;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    irq_route_unit #(.NUM_PINS(NP), .VERSION(8'h11)) i_irq_route_unit (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .msg_valid(msg_valid),
        .msg_ready(msg_ready), .msg_vector(msg_vector), .msg_dest(msg_dest),
        .msg_mode(msg_mode), .msg_logical(msg_logical)
    );

    always #2 clk = ~clk;

    function automatic logic [31:0] exp_lo(logic [7:0] vec, logic [2:0] mode,
            logic lg, logic ds, logic pol, logic rr, logic lvl, logic msk);
        return {15'd0, msk, lvl, rr, pol, ds, lg, mode, vec};
    endfunction

    function automatic logic [7:0] idx_lo(int pin);
        return 8'(16 + 2 * pin);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic win_write(input logic [7:0] idx, input logic [31:0] d);
        bw(8'h00, {24'd0, idx});
        bw(8'h10, d);
    endtask

    task automatic win_read(input logic [7:0] idx, output logic [31:0] d);
        bw(8'h00, {24'd0, idx});
        bus_addr = 8'h10;
        #1 d = bus_rdata;
    endtask

    task automatic read_chk(input string req, input logic [7:0] idx, input logic [31:0] exp);
        logic [31:0] d;
        win_read(idx, d);
        chk(req, d, exp);
    endtask

    task automatic wait_valid();
        for (int k = 0; k < 20 && !msg_valid; k++) @(negedge clk);
    endtask

    task automatic wait_msg(input string req, input logic [7:0] v, input logic [3:0] dst,
                            input logic [2:0] md, input logic lg);
        wait_valid();
        chk({req, " valid"}, {31'd0, msg_valid}, 32'd1);
        chk({req, " vector"}, {24'd0, msg_vector}, {24'd0, v});
        chk({req, " dest"}, {28'd0, msg_dest}, {28'd0, dst});
        chk({req, " mode"}, {28'd0, msg_logical, msg_mode}, {28'd0, lg, md});
        msg_ready = 1'b1;
        @(negedge clk);
        msg_ready = 1'b0;
    endtask

    task automatic no_msg(input string req, input int n);
        bit seen = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (msg_valid) seen = 1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    task automatic eoi(input logic [7:0] v);
        @(negedge clk);
        eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk);
        eoi_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [2:0] modes [6];
        modes = '{3'd0, 3'd1, 3'd2, 3'd4, 3'd5, 3'd7};
        void'($urandom(32'd4711));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Reset state
        chk("R4 no message", {31'd0, msg_valid}, 32'd0);
        bus_addr = 8'h00; #1 chk("R1 select reset", bus_rdata, 32'd0);
        read_chk("R4 entry0 low", idx_lo(0), 32'h0001_0000);
        read_chk("R4 entry23 low", idx_lo(23), 32'h0001_0000);
        read_chk("R4 entry23 high", idx_lo(23) + 8'd1, 32'd0);
        bw(8'h00, 32'h0000_0037);
        bus_addr = 8'h00; #1 chk("R1 select readback", bus_rdata, 32'h37);

        // Identification, version, arbitration
        read_chk("R2 version", 8'h01, 32'h0017_0011);
        win_write(8'h01, 32'hFFFF_FFFF);
        read_chk("R2 version read-only", 8'h01, 32'h0017_0011);
        win_write(8'h00, 32'hFFFF_FFFF);
        read_chk("R2 id", 8'h00, 32'h0F00_0000);
        read_chk("R2 arbitration", 8'h02, 32'h0F00_0000);
        win_write(8'h02, 32'h0000_0000);
        read_chk("R2 arbitration read-only", 8'h02, 32'h0F00_0000);

        // Unmapped indices, read-only bits
        read_chk("R5 unmapped 0x03", 8'h03, 32'd0);
        read_chk("R5 unmapped 0x40", 8'h40, 32'd0);
        win_write(idx_lo(5), 32'hFFFF_FFFF);
        read_chk("R5 R3 low write", idx_lo(5), 32'h0001_AFFF);
        win_write(idx_lo(5) + 8'd1, 32'hFFFF_FFFF);
        read_chk("R3 high write", idx_lo(5) + 8'd1, 32'h0F00_0000);
        no_msg("R11 masked active-low pin", 6);
        win_write(idx_lo(5), 32'h0001_0000);

        // Edge pin with status and hold
        win_write(idx_lo(3) + 8'd1, 32'h0200_0000);
        win_write(idx_lo(3), exp_lo(8'h33, 3'd0, 0, 0, 0, 0, 0, 0));
        pin_in[3] = 1'b1;
        wait_valid();
        read_chk("R9 status pending", idx_lo(3), exp_lo(8'h33, 3'd0, 0, 1, 0, 0, 0, 0));
        repeat (3) @(negedge clk);
        chk("R10 hold vector", {24'd0, msg_vector}, 32'h33);
        wait_msg("R7 edge", 8'h33, 4'd2, 3'd0, 1'b0);
        read_chk("R9 status cleared", idx_lo(3), exp_lo(8'h33, 3'd0, 0, 0, 0, 0, 0, 0));
        no_msg("R7 held asserted", 10);
        pin_in[3] = 1'b0;
        no_msg("R7 falling edge", 4);
        pin_in[3] = 1'b1;
        wait_msg("R7 second edge", 8'h33, 4'd2, 3'd0, 1'b0);
        pin_in[3] = 1'b0;
        win_write(idx_lo(3), 32'h0001_0033);

        // Polarity
        win_write(idx_lo(4), exp_lo(8'h44, 3'd0, 0, 0, 1, 0, 0, 0));
        wait_msg("R6 active low asserts at 0", 8'h44, 4'd0, 3'd0, 1'b0);
        pin_in[4] = 1'b1;
        no_msg("R6 high is inactive", 4);
        pin_in[4] = 1'b0;
        wait_msg("R6 re-assert", 8'h44, 4'd0, 3'd0, 1'b0);
        win_write(idx_lo(4), exp_lo(8'h44, 3'd0, 0, 0, 1, 0, 0, 1));

        // Mask
        win_write(idx_lo(6), exp_lo(8'h66, 3'd0, 0, 0, 0, 0, 0, 1));
        pin_in[6] = 1'b1;
        no_msg("R11 masked edge", 6);
        pin_in[6] = 1'b0;
        @(negedge clk);
        pin_in[6] = 1'b1;
        win_write(idx_lo(6), exp_lo(8'h66, 3'd0, 0, 0, 0, 0, 0, 0));
        no_msg("R11 unmask while held", 8);
        pin_in[6] = 1'b0;
        @(negedge clk);
        pin_in[6] = 1'b1;
        wait_msg("R11 unmasked edge", 8'h66, 4'd0, 3'd0, 1'b0);
        pin_in[6] = 1'b0;
        win_write(idx_lo(6), 32'h0001_0066);

        // Level pin and remote IRR
        win_write(idx_lo(10) + 8'd1, 32'h0100_0000);
        win_write(idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 0, 1, 0));
        pin_in[10] = 1'b1;
        wait_msg("R8 level", 8'h5A, 4'd1, 3'd0, 1'b0);
        read_chk("R8 rirr set", idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 1, 1, 0));
        no_msg("R8 blocked by rirr", 8);
        eoi(8'h11);
        no_msg("R8 foreign eoi", 6);
        read_chk("R8 rirr kept", idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 1, 1, 0));
        eoi(8'h5A);
        wait_msg("R8 reissue after eoi", 8'h5A, 4'd1, 3'd0, 1'b0);

        // Accept and EOI in one cycle
        eoi(8'h5A);
        wait_valid();
        chk("R12 offered", {31'd0, msg_valid}, 32'd1);
        msg_ready = 1'b1; eoi_valid = 1'b1; eoi_vector = 8'h5A;
        @(negedge clk);
        msg_ready = 1'b0; eoi_valid = 1'b0;
        read_chk("R12 rirr wins", idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 1, 1, 0));
        no_msg("R12 no reissue", 8);
        pin_in[10] = 1'b0;
        eoi(8'h5A);
        no_msg("R8 inactive level", 6);
        read_chk("R8 rirr cleared", idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 0, 1, 0));
        win_write(idx_lo(10), exp_lo(8'h5A, 3'd0, 0, 0, 0, 0, 1, 1));

        // Priority
        win_write(idx_lo(1), exp_lo(8'h21, 3'd0, 0, 0, 0, 0, 0, 0));
        win_write(idx_lo(2), exp_lo(8'h22, 3'd0, 0, 0, 0, 0, 0, 0));
        pin_in[2] = 1'b1; pin_in[1] = 1'b1;
        wait_msg("R10 lowest first", 8'h21, 4'd0, 3'd0, 1'b0);
        wait_msg("R10 next", 8'h22, 4'd0, 3'd0, 1'b0);
        pin_in[2] = 1'b0; pin_in[1] = 1'b0;
        win_write(idx_lo(1), 32'h0001_0021);
        win_write(idx_lo(2), 32'h0001_0022);

        // Mode and logical destination carried
        win_write(idx_lo(7) + 8'd1, 32'h0900_0000);
        win_write(idx_lo(7), exp_lo(8'h77, 3'd4, 1, 0, 0, 0, 0, 0));
        pin_in[7] = 1'b1;
        wait_msg("R10 mode fields", 8'h77, 4'd9, 3'd4, 1'b1);
        pin_in[7] = 1'b0;
        win_write(idx_lo(7), 32'h0001_0000);

        // Random mix
        for (int it = 0; it < 24; it++) begin
            int         p;
            logic [7:0] v;
            logic [3:0] d;
            logic [2:0] m;
            logic       lg;
            logic [7:0] ui;
            p  = 12 + int'($urandom % 12);
            v  = 8'($urandom);
            d  = 4'($urandom);
            m  = modes[$urandom % 6];
            lg = 1'($urandom);
            win_write(idx_lo(p) + 8'd1, {4'd0, d, 24'd0});
            win_write(idx_lo(p), exp_lo(v, m, lg, 0, 0, 0, 0, 0));
            read_chk("R3 random layout", idx_lo(p), exp_lo(v, m, lg, 0, 0, 0, 0, 0));
            pin_in[p] = 1'b1;
            wait_msg("R7 random", v, d, m, lg);
            pin_in[p] = 1'b0;
            win_write(idx_lo(p), exp_lo(v, m, lg, 0, 0, 0, 0, 1));
            ui = (it % 2 == 0) ? 8'(3 + $urandom % 13) : 8'(64 + $urandom % 192);
            read_chk("R5 random unmapped", ui, 32'd0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule